// File: doc/BRIEF.md
# Clock-Synchronous Serial Slave with Busy Handshake

This block is a byte-wide serial slave. An external host supplies the transfer clock and the receive data. The block returns data on a push-pull output and drives a busy line that paces the host. The transfer clock idles high. Each byte starts with a falling edge of the transfer clock. The slave captures a receive bit on every rising edge and moves the next transmit bit onto its output on every falling edge, least significant bit first, for eight bits.

All work happens in the system clock domain. The transfer clock and the receive data pass through a multi-stage synchroniser, and both transfer-clock edges are found there. On the system side the block has:
- a one-cycle strobe that carries each completed receive byte;
- a load port that presets the next transmit byte;
- a busy request input, which lets a long internal operation such as a program or erase hold off the host.

The busy output is high from the start of a byte until that byte completes. It is also high for as long as the internal request is asserted, and during reset. When it is low, the host may start the next byte.

Top module: `sync_serial_slave`

## Requirements
- R1: While `rst` is high, `busy_out` is 1, `sdo` is 1 and `rx_valid` is 0. Within 4 system cycles after `rst` falls, with `busy_req` low, `busy_out` is 0. A reset in the middle of a byte discards the partial bits, and the next full byte is received correctly.
- R2: After the eighth rising edge of `sck_in` in a byte, `rx_valid` pulses high for exactly one cycle. With it, `rx_byte` holds the eight `sdi` bits sampled on those rising edges, with the first sampled bit at bit 0.
- R3: A byte presented on `tx_byte` with `tx_load` high for one cycle, while `busy_out` is low, appears on `sdo` least significant bit first. Bit 0 is on `sdo` before the first rising edge. Bit k (k = 1..7) is on `sdo` after the k-th falling edge following the start edge and before the next rising edge.
- R4: When no byte was loaded since the last completed byte, the byte shifted out on `sdo` is 0xFF.
- R5: `busy_out` rises after the falling `sck_in` edge that starts a byte and stays high until that byte's eighth rising edge has been taken.
- R6: When a byte completes and `busy_req` is low, `busy_out` returns to 0 within 5 system cycles after the eighth rising edge is seen.
- R7: While `busy_req` is high, `busy_out` is 1 from the next cycle on, whatever the shift state. This holds across the end of a byte.
- R8: A loaded byte is used for one transfer only. The transfer after it, with no new load, shifts out 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the transfer clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Transfer clock from the host, idle high |
| sdi | input | 1 | Serial receive data, sampled on the rising edge of `sck_in` |
| sdo | output | 1 | Serial transmit data, push-pull, changes after the falling edge of `sck_in` |
| busy_out | output | 1 | High while the slave cannot accept a new byte |
| busy_req | input | 1 | Internal request that holds `busy_out` high |
| tx_load | input | 1 | One-cycle strobe that presets the transmit byte |
| tx_byte | input | DATA_W | Byte to transmit on the next transfer |
| rx_valid | output | 1 | One-cycle strobe marking a completed receive byte |
| rx_byte | output | DATA_W | Last completed receive byte |

## Verification
The assertions take three things for granted about the inputs:
- The transfer clock runs slowly enough that its synchronised edges are several system cycles apart.
- `sdi` changes only at falling edges of `sck_in`.
- The host starts a byte only while `busy_out` is low, and `tx_load` is strobed only in that idle window.

The stimulus respects all three. It holds each transfer-clock phase for eight system cycles, drives every host input on the falling system clock edge, and polls `busy_out` before every byte and every load. The one exception is deliberate: `busy_req` is raised in the middle of a byte to show that the request outlasts the byte's end.

// File: rtl/sss_pkg.sv
package sss_pkg;
  // One-cycle edge events of the synchronised transfer clock
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/sss_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs
module sss_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/sss_rx.sv
// Receive shifter and bit counter
module sss_rx
  import sss_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  sck_evt_t          evt,
  input  logic              sdi_s,
  input  logic              busy_q,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              done,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr;
  logic              start;
  logic [DATA_W-1:0] sr_nxt;

  assign start  = evt.fall & ~busy_q;
  assign done   = evt.rise & (bit_cnt == LAST);
  assign sr_nxt = {sdi_s, sr[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      bit_cnt  <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (evt.rise) begin
        sr      <= sr_nxt;
        bit_cnt <= done ? '0 : bit_cnt + 1'b1;
        if (done) begin
          rx_byte  <= sr_nxt;
          rx_valid <= 1'b1;
        end
      end else if (start) begin
        bit_cnt <= '0;
      end
    end
  end

  // R2
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  busy_during_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt != '0) |-> busy_q);
endmodule

// File: rtl/sss_tx.sv
// Transmit shifter: preset by load, refilled with ones after each byte
module sss_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift,
  input  logic              done,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              sdo
);
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)          sr <= '1;
    else if (tx_load) sr <= tx_byte;
    else if (done)    sr <= '1;
    else if (shift)   sr <= {1'b1, sr[DATA_W-1:1]};
  end

  assign sdo = sr[0];

  // R4
  idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !tx_load) |=> sdo);
endmodule

// File: rtl/sss_busy.sv
// Busy handshake: transfer in progress or internal request
module sss_busy (
  input  logic clk,
  input  logic rst,
  input  logic start_evt,
  input  logic done,
  input  logic busy_req,
  output logic busy_q
);
  logic active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      if (done)                   active <= 1'b0;
      else if (start_evt && !active) active <= 1'b1;
      busy_q <= busy_req | active;
    end
  end
endmodule

// File: rtl/sync_serial_slave.sv
module sync_serial_slave
  import sss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_in,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy_out,
  input  logic              busy_req,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [1:0]       pins_s;
  logic             sck_s, sdi_s, sck_d;
  sck_evt_t         evt;
  logic [CNT_W-1:0] bit_cnt;
  logic             done;
  logic             tx_shift;

  sss_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
    .clk(clk), .rst(rst), .d_in({sck_in, sdi}), .q_out(pins_s));

  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b1;
    else     sck_d <= sck_s;
  end

  assign evt.rise = sck_s & ~sck_d;
  assign evt.fall = ~sck_s & sck_d;
  assign tx_shift = evt.fall & (bit_cnt != '0);

  sss_rx #(.DATA_W(DATA_W)) i_rx (
    .clk(clk), .rst(rst), .evt(evt), .sdi_s(sdi_s), .busy_q(busy_out),
    .bit_cnt(bit_cnt), .done(done), .rx_valid(rx_valid), .rx_byte(rx_byte));

  sss_tx #(.DATA_W(DATA_W)) i_tx (
    .clk(clk), .rst(rst), .shift(tx_shift), .done(done),
    .tx_load(tx_load), .tx_byte(tx_byte), .sdo(sdo));

  sss_busy i_busy (
    .clk(clk), .rst(rst), .start_evt(evt.fall), .done(done),
    .busy_req(busy_req), .busy_q(busy_out));

  // R6
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !busy_req) |=> !busy_out);

  // R7
  busy_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_req |=> busy_out);
endmodule

// File: tb/test_sync_serial_slave.sv
`timescale 1ns/1ps
module test_sync_serial_slave;
  localparam int HALF = 8;  // system cycles per transfer-clock phase

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_in = 1'b1, sdi = 1'b1, busy_req = 1'b0, tx_load = 1'b0;
  logic [7:0] tx_byte = '0;
  logic sdo, busy_out, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0, errs = 0, rx_seen = 0;
  logic [7:0] rx_last = '0;

  always #2.5 clk = ~clk;

  sync_serial_slave i_sync_serial_slave (
    .clk(clk), .rst(rst), .sck_in(sck_in), .sdi(sdi), .sdo(sdo),
    .busy_out(busy_out), .busy_req(busy_req), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte));

  always @(negedge clk) if (rx_valid) begin
    rx_seen++;
    rx_last = rx_byte;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 200 && busy_out; k++) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] got, output logic mid_busy);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_in = 1'b0; sdi = d[i];
      cyc(HALF);
      got[i] = sdo;
      if (i == 3) mid_busy = busy_out;
      sck_in = 1'b1;
      cyc(HALF);
    end
  endtask

  // {load, tx byte, rx byte}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hA5, 8'h3C}, {1'b0, 8'h00, 8'h81}, {1'b1, 8'h01, 8'hFF},
    {1'b1, 8'h80, 8'h00}, {1'b0, 8'h55, 8'h7E}, {1'b1, 8'hC3, 8'h96}};

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic mid;
    int base;
    // R1 reset state
    cyc(4);
    chk(busy_out == 1'b1, "R1 busy in reset", busy_out, 1);
    chk(sdo == 1'b1, "R1 sdo in reset", sdo, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
    rst = 1'b0;
    cyc(4);
    chk(busy_out == 1'b0, "R1 ready after reset", busy_out, 0);

    for (int v = 0; v < 6; v++) begin
      wait_ready();
      if (VEC[v][16]) begin
        tx_byte = VEC[v][15:8]; tx_load = 1'b1;
        cyc(1); tx_load = 1'b0;
      end
      base = rx_seen;
      xfer(VEC[v][7:0], got, mid);
      cyc(8);
      chk(rx_seen == base + 1, "R2 one strobe", rx_seen - base, 1);
      chk(rx_last == VEC[v][7:0], "R2 rx byte", rx_last, VEC[v][7:0]);
      if (VEC[v][16]) chk(got == VEC[v][15:8], "R3 tx byte", got, VEC[v][15:8]);
      else            chk(got == 8'hFF, "R4 R8 idle fill", got, 8'hFF);
      chk(mid == 1'b1, "R5 busy mid byte", mid, 1);
      chk(busy_out == 1'b0, "R6 busy released", busy_out, 0);
    end

    // R7 request while idle
    wait_ready();
    busy_req = 1'b1; cyc(2);
    chk(busy_out == 1'b1, "R7 request idle", busy_out, 1);
    cyc(20);
    chk(busy_out == 1'b1, "R7 request held", busy_out, 1);
    busy_req = 1'b0; cyc(3);
    chk(busy_out == 1'b0, "R7 request released", busy_out, 0);

    // R7 request raised mid byte outlasts completion
    base = rx_seen;
    fork
      xfer(8'h6D, got, mid);
      begin cyc(HALF * 8); busy_req = 1'b1; end
    join
    cyc(8);
    chk(rx_last == 8'h6D, "R7 byte still received", rx_last, 8'h6D);
    chk(busy_out == 1'b1, "R7 busy after byte end", busy_out, 1);
    busy_req = 1'b0; cyc(3);
    chk(busy_out == 1'b0, "R7 released after byte", busy_out, 0);

    // R1 reset mid byte discards partial bits
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sck_in = 1'b0; sdi = 1'b0;
      cyc(HALF); sck_in = 1'b1; cyc(HALF);
    end
    rst = 1'b1; cyc(3);
    chk(busy_out == 1'b1, "R1 busy in mid reset", busy_out, 1);
    rst = 1'b0; cyc(4);
    base = rx_seen;
    xfer(8'h5A, got, mid);
    cyc(8);
    chk(rx_seen == base + 1, "R1 strobe after reset", rx_seen - base, 1);
    chk(rx_last == 8'h5A, "R1 byte after reset", rx_last, 8'h5A);
    chk(got == 8'hFF, "R4 fill after reset", got, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule